// File: doc/BRIEF.md
# Auto-Baud Rate Detector

This block sits in front of a 16x-oversampled UART receiver. It works out the bit period of the incoming line from a known sync character, ASCII 'A' (0x41) or 'a' (0x61). Both codes have a 1 in bit 0 and a 0 in bit 1. Sent LSB first after a low start bit, the line is therefore low for one bit time, high for one bit time, and then low again. Software issues a start command. The block then waits for the line to fall, counts prescaled clock cycles until a chosen edge, and loads the count into the receiver's baud divisor. The receiver carries on capturing the rest of the same character at the new rate.

Two timing windows are offered. With `mode` = 1 only the start bit is timed, from the falling edge to the next rising edge, and the prescaler divides by 16. With `mode` = 0 the start bit and the LSB are timed together, from the falling edge to the next falling edge, and the prescaler divides by 32. In both cases the final count is the divisor for 16x oversampling. While the real rate is still unknown, a burst of 16 back-to-back sample pulses lets the shift register capture the start bit. A measurement that would overflow the divisor width is abandoned and reported as a timeout. In that case the previous divisor is left in place.

The controller is a state machine with six states:
- `ST_IDLE`: waiting for a start command.
- `ST_ARMED`: waiting for the first falling edge on the line.
- `ST_MEAS_START`: timing the start bit.
- `ST_MEAS_LSB`: timing the LSB, used in `mode` = 0 only.
- `ST_LOAD`: writing the divisor, lasting one cycle.
- `ST_ABORT`: reporting a timeout, lasting one cycle.

Its transitions are:
- IDLE→ARMED on `start_req`.
- ARMED→MEAS_START on a synchronized falling edge.
- MEAS_START→LOAD on a rising edge with `mode` = 1.
- MEAS_START→MEAS_LSB on a rising edge with `mode` = 0.
- MEAS_LSB→LOAD on a falling edge.
- MEAS_START→ABORT or MEAS_LSB→ABORT when the counter would overflow.
- LOAD→IDLE and ABORT→IDLE unconditionally.

Top module: `autobaud_detect`

## Requirements
- R1: After reset `div_out` equals the `DIV_INIT` parameter, and `busy`, `done_flag`, `timeout_flag`, `div_load` and `rsr_tick` are all 0.
- R2: `start_req` in the idle state raises `busy` on the next cycle and clears both `done_flag` and `timeout_flag`. While `busy` is high, `start_req` and changes of `mode` have no effect on the run, because `mode` is sampled with the command.
- R3: While armed, a rising edge on `rx_async` is ignored: no sample pulses and no measurement start.
- R4: The falling edge that starts a measurement produces exactly 16 consecutive `rsr_tick` pulses. The first pulse is seen 3 clock cycles after the line falls at the pin, counting two synchronizer stages and one edge-detect stage.
- R5: With `mode` = 1 the loaded divisor is floor(N/16), where N is the number of clock cycles the line stays low in the start bit.
- R6: With `mode` = 0 the loaded divisor is floor(N/32), where N is the number of clock cycles from the first falling edge to the next falling edge (start bit plus LSB).
- R7: `div_load` is high for exactly one cycle, 3 cycles after the ending edge reaches the pin.
- R8: `div_out` takes the new value on the cycle after the `div_load` strobe, and `busy` drops at the same time. At no other time does `div_out` change.
- R9: At completion `done_flag` is set if `irq_en` is 1 and stays 0 otherwise. It holds until the next start command.
- R10: If the rate count would pass all ones (2^DIV_W−1) before the ending edge, the run aborts: `timeout_flag` is set, `busy` clears, no strobe is given and `div_out` keeps its old value.
- R11: An ending edge that arrives in the same cycle as the increment that would overflow wins. The run completes with a divisor of all ones and no timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_async | input | 1 | Serial receive line, asynchronous, idle high |
| start_req | input | 1 | One-cycle command that arms a measurement |
| mode | input | 1 | 1: time start bit only; 0: time start bit plus LSB |
| irq_en | input | 1 | Enables setting of the completion flag |
| div_out | output | DIV_W | Current baud divisor |
| div_load | output | 1 | One-cycle strobe: divisor is being written |
| busy | output | 1 | High from the start command until load or abort |
| done_flag | output | 1 | Sticky end-of-auto-baud flag |
| timeout_flag | output | 1 | Sticky measurement-overflow flag |
| rsr_tick | output | 1 | Sample pulse to the receive shift register |

## Verification
Two functions can fall on the same clock edge: the ending edge that closes the measurement, and the prescaler tick that would push the rate counter past all ones. The bench shrinks the divisor to 10 bits so that both lie within reach. It then holds the start bit low for 16·1024−1 cycles, which makes the final prescaler tick coincide with the sampled rising edge. The run must load 1023 with no timeout. A start bit one cycle longer must instead abort, keep the old divisor and give no strobe.

// File: rtl/abd_pkg.sv
package abd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_ARMED      = 3'd1,
        ST_MEAS_START = 3'd2,
        ST_MEAS_LSB   = 3'd3,
        ST_LOAD       = 3'd4,
        ST_ABORT      = 3'd5
    } abd_state_e;

endpackage

// File: rtl/abd_rx_sync.sv
// Two-stage synchronizer for the serial line plus a one-stage edge detector.
module abd_rx_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_async,
    output logic rx_rise,
    output logic rx_fall
);
    logic meta_q;
    logic sync_q;
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= rx_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rx_rise = sync_q & ~prev_q;
    assign rx_fall = prev_q & ~sync_q;
endmodule

// File: rtl/abd_prescale.sv
// Clock prescaler: divides by OVS for a single-bit window, by 2*OVS for two bits.
module abd_prescale #(
    parameter int unsigned OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_one,
    input  logic run,
    input  logic sel_long,
    output logic tick
);
    localparam int unsigned SPAN_LONG = 2 * OVS;
    localparam int unsigned PRE_W     = $clog2(SPAN_LONG);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] last_v;

    assign last_v = sel_long ? PRE_W'(SPAN_LONG - 1) : PRE_W'(OVS - 1);
    assign tick   = run && (pre_q == last_v);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (load_one) begin
            // the cycle in which the start edge is seen counts as the first one
            pre_q <= PRE_W'(1);
        end else if (run) begin
            if (pre_q == last_v) begin
                pre_q <= '0;
            end else begin
                pre_q <= pre_q + PRE_W'(1);
            end
        end
    end
endmodule

// File: rtl/abd_rate_cnt.sv
// Rate counter with an overflow look-ahead instead of wrap.
module abd_rate_cnt #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    output logic [DIV_W-1:0] count,
    output logic             ovf
);
    logic [DIV_W-1:0] cnt_q;

    assign ovf   = inc && (cnt_q == {DIV_W{1'b1}});
    assign count = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (inc && !ovf) begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/abd_sample_burst.sv
// Emits OVS back-to-back sample pulses after a trigger.
module abd_sample_burst #(
    parameter int unsigned OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pulse
);
    localparam int unsigned BW = $clog2(OVS + 1);

    logic [BW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (fire) begin
            left_q <= BW'(OVS);
        end else if (left_q != '0) begin
            left_q <= left_q - BW'(1);
        end
    end

    assign pulse = (left_q != '0);
endmodule

// File: rtl/autobaud_detect.sv
module autobaud_detect #(
    parameter int unsigned DIV_W    = 16,
    parameter int unsigned OVS      = 16,
    parameter int unsigned DIV_INIT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_async,
    input  logic             start_req,
    input  logic             mode,
    input  logic             irq_en,
    output logic [DIV_W-1:0] div_out,
    output logic             div_load,
    output logic             busy,
    output logic             done_flag,
    output logic             timeout_flag,
    output logic             rsr_tick
);
    import abd_pkg::*;

    abd_state_e state_q;
    abd_state_e state_d;

    logic             rx_rise;
    logic             rx_fall;
    logic             mode_q;
    logic             pre_tick;
    logic             cnt_ovf;
    logic [DIV_W-1:0] rate_cnt;
    logic [DIV_W-1:0] div_q;
    logic             done_q;
    logic             tmo_q;

    // control decoded from the state (output process)
    logic measuring;
    logic end_edge;
    logic meas_go;
    logic meas_run;
    logic st_load;
    logic st_abort;
    logic st_idle;

    abd_rx_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_async (rx_async),
        .rx_rise  (rx_rise),
        .rx_fall  (rx_fall)
    );

    abd_prescale #(.OVS(OVS)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_one (meas_go),
        .run      (meas_run),
        .sel_long (~mode_q),
        .tick     (pre_tick)
    );

    abd_rate_cnt #(.DIV_W(DIV_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (meas_go),
        .inc   (pre_tick),
        .count (rate_cnt),
        .ovf   (cnt_ovf)
    );

    abd_sample_burst #(.OVS(OVS)) u_burst (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (meas_go),
        .pulse (rsr_tick)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic; a closing edge is checked before the overflow
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_req) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (rx_fall) state_d = ST_MEAS_START;
            end
            ST_MEAS_START: begin
                if (rx_rise) begin
                    state_d = mode_q ? ST_LOAD : ST_MEAS_LSB;
                end else if (cnt_ovf) begin
                    state_d = ST_ABORT;
                end
            end
            ST_MEAS_LSB: begin
                if (rx_fall) begin
                    state_d = ST_LOAD;
                end else if (cnt_ovf) begin
                    state_d = ST_ABORT;
                end
            end
            ST_LOAD:  state_d = ST_IDLE;
            ST_ABORT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath controls
    always_comb begin
        st_idle   = 1'b0;
        st_load   = 1'b0;
        st_abort  = 1'b0;
        measuring = 1'b0;
        end_edge  = 1'b0;
        meas_go   = 1'b0;
        unique case (state_q)
            ST_IDLE:       st_idle = 1'b1;
            ST_ARMED:      meas_go = rx_fall;
            ST_MEAS_START: begin
                measuring = 1'b1;
                end_edge  = rx_rise & mode_q;
            end
            ST_MEAS_LSB: begin
                measuring = 1'b1;
                end_edge  = rx_fall;
            end
            ST_LOAD:       st_load  = 1'b1;
            ST_ABORT:      st_abort = 1'b1;
            default:       st_idle  = 1'b1;
        endcase
        meas_run = measuring & ~end_edge;
        busy     = ~st_idle;
        div_load = st_load;
    end

    // mode latch, divisor and sticky flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b1;
            div_q  <= DIV_W'(DIV_INIT);
            done_q <= 1'b0;
            tmo_q  <= 1'b0;
        end else begin
            if (st_idle && start_req) begin
                mode_q <= mode;
                done_q <= 1'b0;
                tmo_q  <= 1'b0;
            end
            if (st_load) begin
                div_q  <= rate_cnt;
                done_q <= irq_en;
            end
            if (st_abort) begin
                tmo_q <= 1'b1;
            end
        end
    end

    assign div_out      = div_q;
    assign done_flag    = done_q;
    assign timeout_flag = tmo_q;
endmodule

// File: rtl/abd_checker.sv
module abd_checker #(
    parameter int unsigned DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_req,
    input logic             irq_en,
    input logic [DIV_W-1:0] div_out,
    input logic             div_load,
    input logic             busy,
    input logic             done_flag,
    input logic             timeout_flag,
    input logic             rsr_tick
);
    assert_arm_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_req) |=> busy);

    assert_tick_only_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsr_tick |-> busy);

    assert_load_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        div_load |=> !div_load);

    assert_div_after_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_out) |-> $past(div_load));

    assert_load_drops_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        div_load |=> !busy);

    assert_done_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> ($past(div_load) && $past(irq_en)));

    assert_abort_keeps_div_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_flag) |-> ($stable(div_out) && !busy));

    assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_flag && timeout_flag));
endmodule

bind autobaud_detect abd_checker #(.DIV_W(DIV_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_req    (start_req),
    .irq_en       (irq_en),
    .div_out      (div_out),
    .div_load     (div_load),
    .busy         (busy),
    .done_flag    (done_flag),
    .timeout_flag (timeout_flag),
    .rsr_tick     (rsr_tick)
);

// File: tb/sim_autobaud_detect.sv
`timescale 1ns/1ps
module sim_autobaud_detect;
    localparam int DW   = 10;
    localparam int INIT = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_async = 1'b1;
    logic          start_req = 1'b0;
    logic          mode = 1'b1;
    logic          irq_en = 1'b1;
    logic [DW-1:0] div_out;
    logic          div_load;
    logic          busy;
    logic          done_flag;
    logic          timeout_flag;
    logic          rsr_tick;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int tick_cnt = 0;
    int tick_first = -1;
    int load_cnt = 0;
    int load_cyc = -1;
    logic tick_prev = 1'b0;

    autobaud_detect #(.DIV_W(DW), .OVS(16), .DIV_INIT(INIT)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_async     (rx_async),
        .start_req    (start_req),
        .mode         (mode),
        .irq_en       (irq_en),
        .div_out      (div_out),
        .div_load     (div_load),
        .busy         (busy),
        .done_flag    (done_flag),
        .timeout_flag (timeout_flag),
        .rsr_tick     (rsr_tick)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rsr_tick) tick_cnt = tick_cnt + 1;
        if (rsr_tick && !tick_prev) tick_first = cyc;
        tick_prev = rsr_tick;
        if (div_load) begin
            load_cnt = load_cnt + 1;
            load_cyc = cyc;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start(input logic m, input logic ie);
        @(negedge clk);
        mode = m;
        irq_en = ie;
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
    endtask

    // Drives one character with bit length len; optionally only the start bit.
    // inj pulses start_req with the other mode during the start bit.
    task automatic drive_char(input int len, input logic [7:0] ch, input bit full,
                              input bit inj, output int c0);
        @(negedge clk);
        rx_async = 1'b0;
        c0 = cyc;
        if (inj) begin
            repeat (5) @(negedge clk);
            start_req = 1'b1;
            mode = ~mode;
            @(negedge clk);
            start_req = 1'b0;
            mode = ~mode;
            repeat (len - 6) @(negedge clk);
        end else begin
            repeat (len) @(negedge clk);
        end
        if (full) begin
            for (int i = 0; i < 8; i++) begin
                rx_async = ch[i];
                repeat (len) @(negedge clk);
            end
        end
        rx_async = 1'b1;
        repeat (full ? len + 8 : 40) @(negedge clk);
    endtask

    task automatic run_case(input string req, input logic m, input logic ie, input int len,
                            input logic [7:0] ch, input bit full, input bit inj,
                            input int exp_div, input int meas);
        int t0, l0, c0;
        t0 = tick_cnt;
        l0 = load_cnt;
        pulse_start(m, ie);
        @(negedge clk);
        chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        chk(done_flag == 1'b0 && timeout_flag == 1'b0, "R2 flags cleared",
            int'({done_flag, timeout_flag}), 0);
        drive_char(len, ch, full, inj, c0);
        chk(int'(div_out) == exp_div, req, int'(div_out), exp_div);
        chk(load_cnt - l0 == 1, "R7 single strobe", load_cnt - l0, 1);
        chk(load_cyc - c0 == meas + 3, "R7 strobe timing", load_cyc - c0, meas + 3);
        chk(busy == 1'b0, "R8 busy cleared", int'(busy), 0);
        chk(tick_cnt - t0 == 16, "R4 burst length", tick_cnt - t0, 16);
        chk(tick_first - c0 == 3, "R4 burst start", tick_first - c0, 3);
        chk(done_flag == ie, "R9 done flag", int'(done_flag), int'(ie));
        chk(timeout_flag == 1'b0, "R11 no timeout", int'(timeout_flag), 0);
    endtask

    task automatic t_reset;
        chk(int'(div_out) == INIT, "R1 divisor init", int'(div_out), INIT);
        chk(!busy && !done_flag && !timeout_flag, "R1 status clear",
            int'({busy, done_flag, timeout_flag}), 0);
        chk(!div_load && !rsr_tick, "R1 strobes idle", int'({div_load, rsr_tick}), 0);
    endtask

    task automatic t_wrong_edge;
        int t0, c0;
        @(negedge clk);
        rx_async = 1'b0;
        repeat (6) @(negedge clk);
        pulse_start(1'b1, 1'b1);
        t0 = tick_cnt;
        rx_async = 1'b1;
        repeat (12) @(negedge clk);
        chk(tick_cnt == t0, "R3 rising edge ignored (ticks)", tick_cnt - t0, 0);
        chk(busy == 1'b1, "R3 still armed", int'(busy), 1);
        drive_char(40, 8'h41, 1'b1, 1'b0, c0);
        chk(int'(div_out) == 2, "R3 measures next fall", int'(div_out), 2);
        chk(load_cyc - c0 == 43, "R3 strobe timing", load_cyc - c0, 43);
    endtask

    task automatic t_timeout;
        int l0, c0, dv;
        dv = int'(div_out);
        l0 = load_cnt;
        pulse_start(1'b1, 1'b1);
        @(negedge clk);
        rx_async = 1'b0;
        c0 = cyc;
        repeat (16400) @(negedge clk);
        chk(timeout_flag == 1'b1, "R10 timeout flag", int'(timeout_flag), 1);
        chk(busy == 1'b0, "R10 busy cleared", int'(busy), 0);
        chk(int'(div_out) == dv, "R10 divisor kept", int'(div_out), dv);
        chk(load_cnt == l0, "R10 no strobe", load_cnt - l0, 0);
        chk(done_flag == 1'b0, "R10 no done", int'(done_flag), 0);
        rx_async = 1'b1;
        repeat (20) @(negedge clk);
        chk(int'(div_out) == dv && c0 > 0, "R10 late edge ignored", int'(div_out), dv);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        // R5: start bit only, exact and fractional lengths
        run_case("R5 mode1 divisor", 1'b1, 1'b1, 40, 8'h41, 1'b1, 1'b0, 2, 40);
        run_case("R5 mode1 fractional", 1'b1, 1'b0, 89, 8'h61, 1'b1, 1'b0, 5, 89);
        // R6: start bit plus LSB; first run also fires start_req mid-run (R2)
        run_case("R6 mode0 divisor", 1'b0, 1'b1, 48, 8'h41, 1'b1, 1'b1, 3, 96);
        run_case("R6 mode0 fractional", 1'b0, 1'b1, 89, 8'h61, 1'b1, 1'b0, 5, 178);
        t_wrong_edge();
        t_timeout();
        // R11: closing edge on the cycle of the overflowing increment
        run_case("R11 boundary all ones", 1'b1, 1'b1, 16383, 8'h41, 1'b0, 1'b0, 1023, 16383);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule